// File: doc/BRIEF.md
# Write-Update Snooping Data Cache

This block is a small direct-mapped data cache that sits between one processor and a shared bus carrying several such caches and main memory. Copies are kept coherent by broadcasting: every processor write goes out on the bus with its address and data. Main memory and every peer cache holding that word update their copies in place. No line is ever invalidated by a peer, and no line is ever dirty. Memory therefore always holds the newest value, and a read miss is filled straight from it.

Each line holds one data word, a tag and a valid bit, and is selected by the low address bits. A processor read that hits returns data in the same cycle. A read miss requests the bus, issues a read command when granted, and completes when memory returns the word, which then replaces the line. A processor write requests the bus and stalls until granted. In the grant cycle the cache drives the update broadcast, completes the write and installs the word locally. The cache also watches update broadcasts from other caches. When one addresses a word it holds, it patches that word.

Top module: `wu_snoop_cache`

## Requirements
- R1: After reset every line is invalid, so the first access to any address misses; during reset cpu_ready_o and bus_req_o are low and bus_cmd_o is idle (0).
- R2: A read whose address matches a valid line completes in the cycle it is presented (cpu_ready_o high, cpu_rdata_o the line data) without requesting the bus.
- R3: A read miss raises bus_req_o; in the grant cycle bus_cmd_o is 1 (read) with bus_addr_o the address; the read completes in the cycle mem_rvalid_i is high, returning mem_rdata_i, and cpu_ready_o stays low until then.
- R4: A write raises bus_req_o and keeps cpu_ready_o low until bus_gnt_i; in the grant cycle bus_cmd_o is 2 (update) with the write address, data and bus_src_o equal to MY_ID, and cpu_ready_o is high in that same cycle.
- R5: A write installs its word in the line selected by its address, whether or not the line held that address before, so a later read of that address hits with the written data.
- R6: Every write produces its own update broadcast; back-to-back writes to one address are not merged.
- R7: An update broadcast from another source whose address matches a valid line replaces that line's data; a later read hits with the broadcast data.
- R8: An update broadcast carrying this cache's own source number leaves its lines unchanged.
- R9: An update broadcast whose address does not match a valid line changes nothing and does not allocate a line.
- R10: A read-miss fill replaces the line of a different address sharing the same index, so the displaced address then misses and is refilled from memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | Processor request, held until cpu_ready_o |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | ADDR_W | Word address |
| cpu_wdata_i | input | DATA_W | Write data |
| cpu_ready_o | output | 1 | Request completes this cycle |
| cpu_rdata_o | output | DATA_W | Read data, valid with cpu_ready_o on reads |
| bus_req_o | output | 1 | Bus request |
| bus_gnt_i | input | 1 | Bus grant |
| bus_cmd_o | output | 2 | 0 idle, 1 read, 2 update broadcast |
| bus_addr_o | output | ADDR_W | Bus address |
| bus_data_o | output | DATA_W | Broadcast data |
| bus_src_o | output | SRC_W | Source number of this cache |
| mem_rvalid_i | input | 1 | Memory read data valid |
| mem_rdata_i | input | DATA_W | Memory read data |
| snp_upd_i | input | 1 | An update broadcast is on the bus |
| snp_src_i | input | SRC_W | Source number of that broadcast |
| snp_addr_i | input | ADDR_W | Address of that broadcast |
| snp_data_i | input | DATA_W | Data of that broadcast |

## Verification
The bench builds the cache with four lines, 8-bit addresses, 16-bit data and source number 1. With only four lines, addresses four apart share a line, which makes tag conflicts, replacement on fill and snoop tag mismatches easy to reach with a handful of addresses. The grant and memory latencies are varied per access to expose the write stall and the fill wait. A second source (2) and a forged own source (1) drive the snoop port, so that in-place patching and self-ignore can be told apart.

// File: rtl/wu_pkg.sv
package wu_pkg;
  typedef enum logic [1:0] {
    BUS_IDLE = 2'd0,
    BUS_RD   = 2'd1,
    BUS_UPD  = 2'd2
  } bus_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARB,
    ST_FILL
  } ctl_state_e;
endpackage

// File: rtl/wu_line_store.sv
module wu_line_store #(
  parameter int LINES  = 4,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16,
  parameter int IDX_W  = $clog2(LINES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic              rd_valid_o,
  output logic [TAG_W-1:0]  rd_tag_o,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic [IDX_W-1:0]  sn_idx_i,
  output logic              sn_valid_o,
  output logic [TAG_W-1:0]  sn_tag_o,
  input  logic              lw_en_i,
  input  logic [IDX_W-1:0]  lw_idx_i,
  input  logic [TAG_W-1:0]  lw_tag_i,
  input  logic [DATA_W-1:0] lw_data_i,
  input  logic              sw_en_i,
  input  logic [IDX_W-1:0]  sw_idx_i,
  input  logic [DATA_W-1:0] sw_data_i
);
  logic [LINES-1:0]  valid_q;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];
  logic [LINES-1:0]  lw_sel, sw_sel;

  for (genvar g = 0; g < LINES; g++) begin : g_sel
    assign lw_sel[g] = lw_en_i && (lw_idx_i == IDX_W'(g));
    assign sw_sel[g] = sw_en_i && (sw_idx_i == IDX_W'(g));
  end

  // local fill/write wins over a snoop patch on the same line
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      for (int i = 0; i < LINES; i++) begin
        tag_q[i]  <= '0;
        data_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < LINES; i++) begin
        if (lw_sel[i]) begin
          valid_q[i] <= 1'b1;
          tag_q[i]   <= lw_tag_i;
          data_q[i]  <= lw_data_i;
        end else if (sw_sel[i]) begin
          data_q[i]  <= sw_data_i;
        end
      end
    end
  end

  assign rd_valid_o = valid_q[rd_idx_i];
  assign rd_tag_o   = tag_q[rd_idx_i];
  assign rd_data_o  = data_q[rd_idx_i];
  assign sn_valid_o = valid_q[sn_idx_i];
  assign sn_tag_o   = tag_q[sn_idx_i];
endmodule

// File: rtl/wu_snoop_match.sv
module wu_snoop_match #(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 6,
  parameter int SRC_W  = 2,
  parameter int MY_ID  = 1
) (
  input  logic              snp_upd_i,
  input  logic [SRC_W-1:0]  snp_src_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  input  logic              line_valid_i,
  input  logic [TAG_W-1:0]  line_tag_i,
  output logic [IDX_W-1:0]  sn_idx_o,
  output logic              sw_en_o
);
  localparam logic [SRC_W-1:0] SelfId = SRC_W'(MY_ID);

  logic foreign, tag_eq;

  assign sn_idx_o = snp_addr_i[IDX_W-1:0];
  assign foreign  = snp_src_i != SelfId;
  assign tag_eq   = line_tag_i == snp_addr_i[ADDR_W-1:IDX_W];
  assign sw_en_o  = snp_upd_i && foreign && line_valid_i && tag_eq;
endmodule

// File: rtl/wu_bus_fsm.sv
module wu_bus_fsm
  import wu_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_ready_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  output logic [1:0]        bus_cmd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_data_o,
  input  logic              mem_rvalid_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [IDX_W-1:0]  rd_idx_o,
  input  logic              rd_valid_i,
  input  logic [TAG_W-1:0]  rd_tag_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              lw_en_o,
  output logic [IDX_W-1:0]  lw_idx_o,
  output logic [TAG_W-1:0]  lw_tag_o,
  output logic [DATA_W-1:0] lw_data_o
);
  ctl_state_e        state_q, state_d;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              capture;
  logic              hit;

  assign rd_idx_o = cpu_addr_i[IDX_W-1:0];
  assign hit      = rd_valid_i && (rd_tag_i == cpu_addr_i[ADDR_W-1:IDX_W]);

  always_comb begin
    state_d     = state_q;
    capture     = 1'b0;
    cpu_ready_o = 1'b0;
    cpu_rdata_o = rd_data_i;
    bus_req_o   = 1'b0;
    bus_cmd_o   = BUS_IDLE;
    lw_en_o     = 1'b0;
    lw_data_o   = wdata_q;
    unique case (state_q)
      ST_IDLE: begin
        if (cpu_req_i) begin
          if (!cpu_we_i && hit) begin
            cpu_ready_o = 1'b1;
          end else begin
            capture = 1'b1;
            state_d = ST_ARB;
          end
        end
      end
      ST_ARB: begin
        bus_req_o = 1'b1;
        if (bus_gnt_i) begin
          if (we_q) begin
            // broadcast cycle doubles as write completion
            bus_cmd_o   = BUS_UPD;
            lw_en_o     = 1'b1;
            cpu_ready_o = 1'b1;
            state_d     = ST_IDLE;
          end else begin
            bus_cmd_o = BUS_RD;
            state_d   = ST_FILL;
          end
        end
      end
      ST_FILL: begin
        if (mem_rvalid_i) begin
          lw_en_o     = 1'b1;
          lw_data_o   = mem_rdata_i;
          cpu_ready_o = 1'b1;
          cpu_rdata_o = mem_rdata_i;
          state_d     = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      state_q <= state_d;
      if (capture) begin
        we_q    <= cpu_we_i;
        addr_q  <= cpu_addr_i;
        wdata_q <= cpu_wdata_i;
      end
    end
  end

  assign bus_addr_o = addr_q;
  assign bus_data_o = wdata_q;
  assign lw_idx_o   = addr_q[IDX_W-1:0];
  assign lw_tag_o   = addr_q[ADDR_W-1:IDX_W];
endmodule

// File: rtl/wu_snoop_cache.sv
module wu_snoop_cache #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int LINES  = 4,
  parameter int SRC_W  = 2,
  parameter int MY_ID  = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_ready_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  output logic [1:0]        bus_cmd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_data_o,
  output logic [SRC_W-1:0]  bus_src_o,
  input  logic              mem_rvalid_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              snp_upd_i,
  input  logic [SRC_W-1:0]  snp_src_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  input  logic [DATA_W-1:0] snp_data_i
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  rd_idx, sn_idx, lw_idx;
  logic              rd_valid, sn_valid, lw_en, sw_en;
  logic [TAG_W-1:0]  rd_tag, sn_tag, lw_tag;
  logic [DATA_W-1:0] rd_data, lw_data;

  assign bus_src_o = SRC_W'(MY_ID);

  wu_bus_fsm #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .TAG_W(TAG_W)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cpu_req_i   (cpu_req_i),
    .cpu_we_i    (cpu_we_i),
    .cpu_addr_i  (cpu_addr_i),
    .cpu_wdata_i (cpu_wdata_i),
    .cpu_ready_o (cpu_ready_o),
    .cpu_rdata_o (cpu_rdata_o),
    .bus_req_o   (bus_req_o),
    .bus_gnt_i   (bus_gnt_i),
    .bus_cmd_o   (bus_cmd_o),
    .bus_addr_o  (bus_addr_o),
    .bus_data_o  (bus_data_o),
    .mem_rvalid_i(mem_rvalid_i),
    .mem_rdata_i (mem_rdata_i),
    .rd_idx_o    (rd_idx),
    .rd_valid_i  (rd_valid),
    .rd_tag_i    (rd_tag),
    .rd_data_i   (rd_data),
    .lw_en_o     (lw_en),
    .lw_idx_o    (lw_idx),
    .lw_tag_o    (lw_tag),
    .lw_data_o   (lw_data)
  );

  wu_snoop_match #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .SRC_W(SRC_W), .MY_ID(MY_ID)
  ) u_snoop (
    .snp_upd_i   (snp_upd_i),
    .snp_src_i   (snp_src_i),
    .snp_addr_i  (snp_addr_i),
    .line_valid_i(sn_valid),
    .line_tag_i  (sn_tag),
    .sn_idx_o    (sn_idx),
    .sw_en_o     (sw_en)
  );

  wu_line_store #(
    .LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W), .IDX_W(IDX_W)
  ) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_idx_i  (rd_idx),
    .rd_valid_o(rd_valid),
    .rd_tag_o  (rd_tag),
    .rd_data_o (rd_data),
    .sn_idx_i  (sn_idx),
    .sn_valid_o(sn_valid),
    .sn_tag_o  (sn_tag),
    .lw_en_i   (lw_en),
    .lw_idx_i  (lw_idx),
    .lw_tag_i  (lw_tag),
    .lw_data_i (lw_data),
    .sw_en_i   (sw_en),
    .sw_idx_i  (sn_idx),
    .sw_data_i (snp_data_i)
  );
endmodule

// File: rtl/wu_snoop_cache_chk.sv
module wu_snoop_cache_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int SRC_W  = 2,
  parameter int MY_ID  = 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cpu_req_i,
  input logic              cpu_we_i,
  input logic              cpu_ready_o,
  input logic              bus_req_o,
  input logic              bus_gnt_i,
  input logic [1:0]        bus_cmd_o,
  input logic [SRC_W-1:0]  bus_src_o,
  input logic              mem_rvalid_i
);
  AST_CMD_NEEDS_GNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_cmd_o != 2'd0) |-> (bus_req_o && bus_gnt_i)); // R4

  AST_UPD_COMPLETES_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_cmd_o == 2'd2) |-> (cpu_ready_o && cpu_we_i && bus_src_o == SRC_W'(MY_ID))); // R4

  AST_WRITE_STALLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_req_i && cpu_we_i && !bus_gnt_i) |-> !cpu_ready_o); // R4

  AST_HIT_NO_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_ready_o && !cpu_we_i && !mem_rvalid_i) |-> !bus_req_o); // R2

  AST_NO_REQ_AFTER_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_cmd_o == 2'd1) |=> !bus_req_o); // R3

  AST_CMD_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(bus_cmd_o)); // R6
endmodule

bind wu_snoop_cache wu_snoop_cache_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SRC_W(SRC_W), .MY_ID(MY_ID)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cpu_req_i   (cpu_req_i),
  .cpu_we_i    (cpu_we_i),
  .cpu_ready_o (cpu_ready_o),
  .bus_req_o   (bus_req_o),
  .bus_gnt_i   (bus_gnt_i),
  .bus_cmd_o   (bus_cmd_o),
  .bus_src_o   (bus_src_o),
  .mem_rvalid_i(mem_rvalid_i)
);

// File: tb/wu_snoop_cache_tb_top.sv
`timescale 1ns/1ps
module wu_snoop_cache_tb_top;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;
  localparam int LINES  = 4;
  localparam int SRC_W  = 2;
  localparam int MY_ID  = 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cpu_req = 1'b0, cpu_we = 1'b0;
  logic [ADDR_W-1:0] cpu_addr = '0;
  logic [DATA_W-1:0] cpu_wdata = '0;
  logic              cpu_ready;
  logic [DATA_W-1:0] cpu_rdata;
  logic              bus_req, bus_gnt = 1'b0;
  logic [1:0]        bus_cmd;
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_data;
  logic [SRC_W-1:0]  bus_src;
  logic              mem_rvalid = 1'b0;
  logic [DATA_W-1:0] mem_rdata = '0;
  logic              snp_upd = 1'b0;
  logic [SRC_W-1:0]  snp_src = '0;
  logic [ADDR_W-1:0] snp_addr = '0;
  logic [DATA_W-1:0] snp_data = '0;

  always #10 clk = ~clk;

  wu_snoop_cache #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES), .SRC_W(SRC_W), .MY_ID(MY_ID)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata),
    .cpu_ready_o(cpu_ready), .cpu_rdata_o(cpu_rdata),
    .bus_req_o(bus_req), .bus_gnt_i(bus_gnt), .bus_cmd_o(bus_cmd),
    .bus_addr_o(bus_addr), .bus_data_o(bus_data), .bus_src_o(bus_src),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .snp_upd_i(snp_upd), .snp_src_i(snp_src), .snp_addr_i(snp_addr), .snp_data_i(snp_data)
  );

  // reference model: memory plus per-line contents
  int  mem [256];
  bit  m_valid [LINES];
  int  m_tag [LINES];
  int  m_data [LINES];
  int  checks = 0, errors = 0;
  int  upd_exp = 0, upd_seen = 0;
  bit  done = 1'b0;

  always @(posedge clk) if (rst_n && bus_cmd == 2'd2) upd_seen++;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  // one processor access; gnt_dly/mem_dly in cycles
  task automatic cpu_op(input bit we, input int addr, input int data,
                        input int gnt_dly, input int mem_dly, input string rq);
    int idx = addr % LINES;
    int tg  = addr / LINES;
    bit hit = m_valid[idx] && (m_tag[idx] == tg);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = ADDR_W'(addr); cpu_wdata = DATA_W'(data);
    #5;
    if (!we && hit) begin
      chk(cpu_ready == 1'b1, {rq, " hit ready"}, int'(cpu_ready), 1);
      chk(int'(cpu_rdata) == m_data[idx], {rq, " hit data"}, int'(cpu_rdata), m_data[idx]);
      chk(bus_req == 1'b0, {rq, " hit no bus"}, int'(bus_req), 0);
      @(negedge clk);
      cpu_req = 1'b0;
      return;
    end
    chk(cpu_ready == 1'b0, {rq, " miss/write not ready"}, int'(cpu_ready), 0);
    for (int c = 0; c <= gnt_dly; c++) begin
      @(negedge clk);
      bus_gnt = (c == gnt_dly);
      #5;
      chk(bus_req == 1'b1, {rq, " bus_req"}, int'(bus_req), 1);
      if (c < gnt_dly) begin
        chk(cpu_ready == 1'b0 && bus_cmd == 2'd0, {rq, " stall"},
            int'({cpu_ready, bus_cmd}), 0);
      end else begin
        chk(int'(bus_cmd) == (we ? 2 : 1), {rq, " cmd"}, int'(bus_cmd), we ? 2 : 1);
        chk(int'(bus_addr) == addr, {rq, " addr"}, int'(bus_addr), addr);
        chk(cpu_ready == we, {rq, " ready at grant"}, int'(cpu_ready), int'(we));
        if (we) begin
          chk(int'(bus_data) == data && int'(bus_src) == MY_ID, {rq, " data/src"},
              int'(bus_data), data);
        end
      end
    end
    if (we) begin
      upd_exp++;
      mem[addr] = data;
      m_valid[idx] = 1'b1; m_tag[idx] = tg; m_data[idx] = data;
      @(negedge clk);
      bus_gnt = 1'b0; cpu_req = 1'b0;
      return;
    end
    for (int c = 0; c <= mem_dly; c++) begin
      @(negedge clk);
      bus_gnt = 1'b0;
      mem_rvalid = (c == mem_dly);
      mem_rdata = DATA_W'(mem[addr]);
      #5;
      chk(bus_req == 1'b0, {rq, " no bus during fill"}, int'(bus_req), 0);
      chk(cpu_ready == (c == mem_dly), {rq, " fill ready"}, int'(cpu_ready), int'(c == mem_dly));
      if (c == mem_dly)
        chk(int'(cpu_rdata) == mem[addr], {rq, " fill data"}, int'(cpu_rdata), mem[addr]);
    end
    m_valid[idx] = 1'b1; m_tag[idx] = tg; m_data[idx] = mem[addr];
    @(negedge clk);
    mem_rvalid = 1'b0; cpu_req = 1'b0;
  endtask

  task automatic snoop(input int src, input int addr, input int data);
    int idx = addr % LINES;
    @(negedge clk);
    snp_upd = 1'b1; snp_src = SRC_W'(src); snp_addr = ADDR_W'(addr); snp_data = DATA_W'(data);
    @(negedge clk);
    snp_upd = 1'b0;
    if (src != MY_ID) begin
      mem[addr] = data;
      if (m_valid[idx] && m_tag[idx] == addr / LINES) m_data[idx] = data;
    end
  endtask

  initial begin
    for (int a = 0; a < 256; a++) mem[a] = (a * 37 + 16'h0100) & 16'hFFFF;
    for (int i = 0; i < LINES; i++) begin
      m_valid[i] = 1'b0; m_tag[i] = 0; m_data[i] = 0;
    end
    cpu_addr = 8'h05; cpu_req = 1'b1;
    repeat (3) @(negedge clk);
    #5;
    chk(cpu_ready == 1'b0 && bus_req == 1'b0 && bus_cmd == 2'd0, "R1 reset outputs",
        int'({cpu_ready, bus_req, bus_cmd}), 0);
    @(negedge clk);
    cpu_req = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    cpu_op(1'b0, 8'h05, 0, 0, 1, "R1 R3 first read misses");
    cpu_op(1'b0, 8'h05, 0, 0, 0, "R2 read hit");
    cpu_op(1'b1, 8'h05, 16'hBEEF, 3, 0, "R4 write stalls for grant");
    cpu_op(1'b0, 8'h05, 0, 0, 0, "R5 read after write");
    cpu_op(1'b1, 8'h22, 16'h1357, 0, 0, "R5 write miss allocates");
    cpu_op(1'b0, 8'h22, 0, 0, 0, "R5 read allocated line");
    upd_seen = 0; upd_exp = 0;
    cpu_op(1'b1, 8'h22, 16'hA001, 1, 0, "R6 write one");
    cpu_op(1'b1, 8'h22, 16'hA002, 0, 0, "R6 write two");
    chk(upd_seen == upd_exp && upd_exp == 2, "R6 broadcast count", upd_seen, upd_exp);
    cpu_op(1'b0, 8'h22, 0, 0, 0, "R6 last value held");

    snoop(2, 8'h05, 16'h1234);
    cpu_op(1'b0, 8'h05, 0, 0, 0, "R7 snoop patch read");
    snoop(MY_ID, 8'h05, 16'h9999);
    cpu_op(1'b0, 8'h05, 0, 0, 0, "R8 own broadcast ignored");
    snoop(2, 8'h09, 16'h4242);
    cpu_op(1'b0, 8'h05, 0, 0, 0, "R9 tag mismatch ignored");
    snoop(2, 8'h03, 16'h7777);
    cpu_op(1'b0, 8'h03, 0, 0, 2, "R9 invalid line not allocated");
    cpu_op(1'b0, 8'h09, 0, 2, 0, "R10 conflicting fill");
    cpu_op(1'b0, 8'h05, 0, 0, 1, "R10 displaced address refills");
    cpu_op(1'b0, 8'h09, 0, 0, 1, "R10 displaced again");

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      summary();
      $finish;
    end
  end
endmodule